// File: doc/BRIEF.md
# Delay-Line Snapshot Silo Capture

This block sits behind a tapped delay line used for time-to-digital conversion. On every reference clock edge it records the complete tap vector and pushes it into a short stack of parallel shift registers, the silo. Each level of the silo holds one earlier sample, so the stack always contains the most recent few snapshots of the line. A rising-edge detector watches the far end of the line. When a pulse has travelled the full length of the line, a small state machine freezes the silo together with a free-running coarse clock count. It then streams the frozen frame into a 16-bit FIFO write port, one word per clock.

Every raw tap bit is kept; nothing is reduced to a count or a thermometer code. Host software can therefore calibrate the line and recover several stops from one frame. While a frame is being streamed, further pulses are not captured. They are counted in a saturating drop counter. The FIFO full flag stalls the stream without losing or repeating any word.

Top module: `tdc_silo_capture`

## Requirements
- R1: While reset is high and in the first cycle after it, `fifo_wr_o` is 0 and `drop_count_o` is 0; the coarse count restarts from 0 after every reset.
- R2: On every clock edge outside reset, the tap vector enters silo level 0 and each level moves down by one, whether or not a pulse is present.
- R3: A pulse event is reported only when the registered far-end sample goes from 0 to 1. A far-end level held high for many cycles yields exactly one event.
- R4: When an event is reported while the block is idle, the next edge captures the frame. The silo part of the frame is the FLOORS most recent tap samples, level 0 being the sample taken on the same edge that registered the rising far-end value.
- R5: The frame begins with the coarse stamp, least significant 16-bit word first. The stamp equals the number of clock edges since reset release, up to and including the edge that registered the rising far-end value.
- R6: After the stamp, the silo is sent as the concatenation {level FLOORS-1, ..., level 1, level 0}, cut into 16-bit words from the least significant end. The unused upper bits of the final word are 0. With 24 taps, 3 levels and a 16-bit stamp, a frame is 6 words and the last word carries 8 zero bits.
- R7: Once a frame is captured, `fifo_wr_o` is high in every following cycle in which `fifo_full_i` is low, until all words of the frame are written. No write happens while idle.
- R8: While `fifo_full_i` is high, `fifo_wr_o` stays low and `fifo_data_o` holds its word. No word is dropped or repeated.
- R9: Events reported while a frame is being streamed, including the cycle of its final write, are not captured. Each one increments `drop_count_o`, which saturates at all ones.
- R10: An event reported in the cycle after the final word of a frame is written starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| tap_i | input | TAPS | Delay-line tap vector, sampled every edge |
| last_tap_i | input | 1 | Far end of the delay line, fed to the edge detector |
| fifo_full_i | input | 1 | FIFO full; stalls the word stream |
| fifo_wr_o | output | 1 | FIFO write strobe |
| fifo_data_o | output | WORD_W | FIFO write data |
| drop_count_o | output | DROP_W | Saturating count of events lost during a transfer |

## Verification
Faults in the silo or in the frame holding register appear in the very next frame as wrong bits in specific word positions. The bench compares every written word against a frame it builds from the tap vectors it drove itself. A wrong state-machine state or word index shows within one cycle: as a missing strobe while the FIFO has room, an extra word, or a frame of the wrong length. A wrong drop counter shows as soon as the port value is compared after a burst of pulses, and a missing saturation shows after a long stalled transfer.

// File: rtl/tdc_silo_pkg.sv
package tdc_silo_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_SEND = 1'b1
  } cap_state_t;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

endpackage

// File: rtl/tdc_edge_detect.sv
module tdc_edge_detect (
  input  logic clk,
  input  logic rst,
  input  logic line_end_i,
  output logic rise_o
);

  logic cur_q;
  logic prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q  <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      cur_q  <= line_end_i;
      prev_q <= cur_q;
    end
  end

  assign rise_o = cur_q & ~prev_q;

  AST_SINGLE_RISE: assert property (@(posedge clk) disable iff (rst)
    rise_o |=> !rise_o); // R3

endmodule

// File: rtl/tdc_silo_bank.sv
module tdc_silo_bank #(
  parameter int TAPS   = 24,
  parameter int FLOORS = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [TAPS-1:0]          tap_i,
  output logic [TAPS*FLOORS-1:0]   flat_o
);

  logic [TAPS-1:0] level_q [FLOORS];

  always_ff @(posedge clk) begin
    if (rst) level_q[0] <= '0;
    else     level_q[0] <= tap_i;
  end

  for (genvar k = 1; k < FLOORS; k++) begin : g_level
    always_ff @(posedge clk) begin
      if (rst) level_q[k] <= '0;
      else     level_q[k] <= level_q[k-1];
    end
  end

  for (genvar k = 0; k < FLOORS; k++) begin : g_flat
    assign flat_o[k*TAPS +: TAPS] = level_q[k];
  end

endmodule

// File: rtl/tdc_stream_out.sv
module tdc_stream_out
  import tdc_silo_pkg::*;
#(
  parameter int TAPS   = 24,
  parameter int FLOORS = 3,
  parameter int CNT_W  = 16,
  parameter int WORD_W = 16,
  parameter int DROP_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   event_i,
  input  logic [CNT_W-1:0]       stamp_i,
  input  logic [TAPS*FLOORS-1:0] silo_i,
  input  logic                   fifo_full_i,
  output logic                   fifo_wr_o,
  output logic [WORD_W-1:0]      fifo_data_o,
  output logic [DROP_W-1:0]      drop_count_o
);

  localparam int SILO_BITS   = TAPS * FLOORS;
  localparam int STAMP_WORDS = ceil_div(CNT_W, WORD_W);
  localparam int SILO_WORDS  = ceil_div(SILO_BITS, WORD_W);
  localparam int TOTAL_WORDS = STAMP_WORDS + SILO_WORDS;
  localparam int TOTAL_BITS  = TOTAL_WORDS * WORD_W;
  localparam int SILO_LSB    = STAMP_WORDS * WORD_W;
  localparam int IDX_W       = $clog2(TOTAL_WORDS + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(TOTAL_WORDS - 1);

  cap_state_t            state_q;
  logic [TOTAL_BITS-1:0] frame_c;
  logic [TOTAL_BITS-1:0] hold_q;
  logic [IDX_W-1:0]      idx_q;
  logic [DROP_W-1:0]     drop_q;
  logic                  send_c;

  always_comb begin
    frame_c = '0;
    frame_c[CNT_W-1:0] = stamp_i;
    frame_c[SILO_LSB +: SILO_BITS] = silo_i;
  end

  assign send_c = (state_q == ST_SEND) && !fifo_full_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      hold_q  <= '0;
      idx_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: begin
          if (event_i) begin
            hold_q  <= frame_c;
            idx_q   <= '0;
            state_q <= ST_SEND;
          end
        end
        ST_SEND: begin
          if (send_c) begin
            hold_q <= hold_q >> WORD_W;
            if (idx_q == LAST_IDX) state_q <= ST_IDLE;
            else                   idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      drop_q <= '0;
    end else if ((state_q == ST_SEND) && event_i && (drop_q != '1)) begin
      drop_q <= drop_q + 1'b1;
    end
  end

  assign fifo_wr_o    = send_c;
  assign fifo_data_o  = hold_q[WORD_W-1:0];
  assign drop_count_o = drop_q;

  AST_CAPTURE_START: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && event_i) |=> (state_q == ST_SEND)); // R4

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SEND && fifo_full_i) |=> $stable(fifo_data_o)); // R8

  AST_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    (fifo_wr_o && idx_q == LAST_IDX) |=> !fifo_wr_o); // R7

  AST_DROP_MONO: assert property (@(posedge clk) disable iff (rst)
    drop_count_o >= $past(drop_count_o)); // R9

endmodule

// File: rtl/tdc_silo_capture.sv
module tdc_silo_capture #(
  parameter int TAPS   = 24,
  parameter int FLOORS = 3,
  parameter int CNT_W  = 16,
  parameter int WORD_W = 16,
  parameter int DROP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [TAPS-1:0]   tap_i,
  input  logic              last_tap_i,
  input  logic              fifo_full_i,
  output logic              fifo_wr_o,
  output logic [WORD_W-1:0] fifo_data_o,
  output logic [DROP_W-1:0] drop_count_o
);

  localparam int SILO_BITS = TAPS * FLOORS;

  logic [CNT_W-1:0]     coarse_q;
  logic [SILO_BITS-1:0] silo_flat;
  logic                 rise;

  always_ff @(posedge clk) begin
    if (rst) coarse_q <= '0;
    else     coarse_q <= coarse_q + 1'b1;
  end

  tdc_silo_bank #(
    .TAPS   (TAPS),
    .FLOORS (FLOORS)
  ) u_silo (
    .clk    (clk),
    .rst    (rst),
    .tap_i  (tap_i),
    .flat_o (silo_flat)
  );

  tdc_edge_detect u_edge (
    .clk        (clk),
    .rst        (rst),
    .line_end_i (last_tap_i),
    .rise_o     (rise)
  );

  tdc_stream_out #(
    .TAPS   (TAPS),
    .FLOORS (FLOORS),
    .CNT_W  (CNT_W),
    .WORD_W (WORD_W),
    .DROP_W (DROP_W)
  ) u_stream (
    .clk          (clk),
    .rst          (rst),
    .event_i      (rise),
    .stamp_i      (coarse_q),
    .silo_i       (silo_flat),
    .fifo_full_i  (fifo_full_i),
    .fifo_wr_o    (fifo_wr_o),
    .fifo_data_o  (fifo_data_o),
    .drop_count_o (drop_count_o)
  );

endmodule

// File: tb/tdc_silo_capture_test.sv
module tdc_silo_capture_test;

  localparam int M     = 24;
  localparam int F     = 3;
  localparam int NW    = 6;
  localparam int CLK_P = 20;

  // entry: bit25 = fifo full, bit24 = far-end level, bits 23:0 = taps
  localparam logic [25:0] STIM [0:19] = '{
    {1'b0, 1'b0, 24'h000000}, {1'b0, 1'b0, 24'h00000F}, {1'b0, 1'b1, 24'h0000FF},
    {1'b0, 1'b1, 24'h00FFFF}, {1'b0, 1'b1, 24'hA5A5A5}, {1'b0, 1'b1, 24'h123456},
    {1'b0, 1'b0, 24'hFFFFFF}, {1'b0, 1'b0, 24'h0F0F0F}, {1'b0, 1'b0, 24'h800001},
    {1'b0, 1'b0, 24'h000001}, {1'b0, 1'b0, 24'h00000E}, {1'b0, 1'b1, 24'h7FFFFE},
    {1'b1, 1'b1, 24'hC3C3C3}, {1'b1, 1'b0, 24'h3C3C3C}, {1'b1, 1'b1, 24'hDEADBE},
    {1'b0, 1'b0, 24'h111111}, {1'b1, 1'b1, 24'h222222}, {1'b0, 1'b1, 24'h333333},
    {1'b0, 1'b0, 24'h444444}, {1'b0, 1'b1, 24'h555555}
  };

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [M-1:0]    tap_i = '0;
  logic            last_tap_i = 1'b0;
  logic            fifo_full_i = 1'b0;
  logic            fifo_wr_o;
  logic [15:0]     fifo_data_o;
  logic [7:0]      drop_count_o;

  int nchk = 0;
  int nerr = 0;
  int head = 0;
  int tail = 0;
  int pend = 0;
  int ovf_exp = 0;
  int wr_total = 0;
  bit done = 1'b0;
  logic saw_wr = 1'b0;
  logic m_s1, m_s2, m_rise;
  logic [M-1:0] h0, h1, h2;
  logic [15:0] m_cnt;
  logic [95:0] frame;
  logic [15:0] exp_w [0:4095];

  tdc_silo_capture uut (
    .clk          (clk),
    .rst          (rst),
    .tap_i        (tap_i),
    .last_tap_i   (last_tap_i),
    .fifo_full_i  (fifo_full_i),
    .fifo_wr_o    (fifo_wr_o),
    .fifo_data_o  (fifo_data_o),
    .drop_count_o (drop_count_o)
  );

  always #(CLK_P/2) clk = ~clk;

  // Frame prediction from the driven inputs (R2, R4, R5, R6, R9, R10)
  always @(posedge clk) begin
    if (rst) begin
      m_s1 = 1'b0; m_s2 = 1'b0;
      h0 = '0; h1 = '0; h2 = '0;
      m_cnt = '0; pend = 0; head = 0; tail = 0; ovf_exp = 0;
    end else begin
      m_rise = m_s1 & ~m_s2;
      if (pend > 0) begin
        if (m_rise && ovf_exp != 255) ovf_exp++;
        if (saw_wr) pend--;
      end else if (m_rise) begin
        frame = {8'h00, h2, h1, h0, m_cnt};
        for (int k = 0; k < NW; k++) exp_w[tail + k] = frame[16*k +: 16];
        tail += NW;
        pend = NW;
      end
      m_s2 = m_s1; m_s1 = last_tap_i;
      h2 = h1; h1 = h0; h0 = tap_i;
      m_cnt = m_cnt + 16'd1;
    end
  end

  // Port monitor, sampled 5 ns after the falling edge
  always begin
    @(negedge clk);
    #5;
    saw_wr = fifo_wr_o;
    if (!rst) begin
      if (fifo_wr_o) begin
        wr_total++;
        nchk++;
        if (fifo_full_i) begin
          nerr++;
          $display("FAIL R8: write while full, got wr=%0b expected 0", fifo_wr_o);
        end
        if (head == tail) begin
          nerr++;
          $display("FAIL R7: unexpected write data=%h expected none", fifo_data_o);
        end else begin
          if (fifo_data_o !== exp_w[head]) begin
            nerr++;
            $display("FAIL R2 R4 R5 R6: word %0d got %h expected %h", head, fifo_data_o, exp_w[head]);
          end
          head++;
        end
      end else if (pend > 0) begin
        nchk++;
        if (!fifo_full_i) begin
          nerr++;
          $display("FAIL R7: missing write, got wr=0 expected 1");
        end
      end
    end
  end

  task automatic step(input logic [M-1:0] t, input logic l, input logic f);
    @(negedge clk);
    tap_i = t; last_tap_i = l; fifo_full_i = f;
  endtask

  task automatic check(input bit ok, input string tag, input int got, input int expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d", tag, got, expv);
    end
  endtask

  task automatic drain(input int n);
    for (int i = 0; i < n; i++) step('0, 1'b0, 1'b0);
    @(negedge clk); #7;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: got hang expected finish");
      $display("Result: errors=%0d of %0d checks", nerr, nchk + 1);
      $finish;
    end
  end

  initial begin
    int base;
    int d0;
    for (int i = 0; i < 3; i++) step(24'hFFFFFF, 1'b1, 1'b0);
    #7;
    check(fifo_wr_o == 1'b0, "R1 wr in reset", int'(fifo_wr_o), 0);
    check(drop_count_o == 8'd0, "R1 drop in reset", int'(drop_count_o), 0);
    @(negedge clk); rst = 1'b0; tap_i = '0; last_tap_i = 1'b0;
    #7;
    check(fifo_wr_o == 1'b0, "R1 wr after reset", int'(fifo_wr_o), 0);

    // table walk
    for (int i = 0; i < 20; i++) step(STIM[i][23:0], STIM[i][24], STIM[i][25]);
    drain(16);
    check(head == tail && pend == 0, "R7 table frames complete", tail - head, 0);
    check(int'(drop_count_o) == ovf_exp, "R9 table drops", int'(drop_count_o), ovf_exp);

    // R3: far end held high gives one frame
    base = wr_total;
    step(24'h0000AA, 1'b0, 1'b0);
    for (int i = 0; i < 20; i++) step(24'h00AA00 + 24'(i), 1'b1, 1'b0);
    drain(10);
    check(wr_total - base == NW, "R3 held high one frame", wr_total - base, NW);

    // R10: new event right after final word
    base = wr_total;
    d0 = int'(drop_count_o);
    for (int i = 0; i < 6; i++) step(24'h5A0000 + 24'(i), 1'b1, 1'b0);
    step(24'h5A0006, 1'b0, 1'b0);
    step(24'h5A0007, 1'b1, 1'b0);
    drain(12);
    check(wr_total - base == 2 * NW, "R10 back-to-back frames", wr_total - base, 2 * NW);
    check(int'(drop_count_o) == d0, "R10 no drop", int'(drop_count_o), d0);

    // R8: long stall mid-frame
    base = wr_total;
    step(24'hF00000, 1'b0, 1'b0);
    step(24'hF00001, 1'b1, 1'b0);
    step(24'hF00002, 1'b0, 1'b0);
    step(24'hF00003, 1'b0, 1'b0);
    for (int i = 0; i < 10; i++) step(24'hE00000 + 24'(i), 1'b0, 1'b1);
    drain(10);
    check(wr_total - base == NW, "R8 stalled frame complete", wr_total - base, NW);

    // R9: saturation of the drop counter
    step(24'h000123, 1'b1, 1'b0);
    step(24'h000456, 1'b0, 1'b1);
    for (int i = 0; i < 300; i++) begin
      step(24'(i), 1'b1, 1'b1);
      step(24'(i), 1'b0, 1'b1);
    end
    drain(12);
    check(drop_count_o == 8'd255, "R9 saturation", int'(drop_count_o), 255);
    check(int'(drop_count_o) == ovf_exp, "R9 model match", int'(drop_count_o), ovf_exp);

    // R1/R5: second reset restarts stamp and clears drops
    @(negedge clk); rst = 1'b1;
    step('0, 1'b0, 1'b0);
    step('0, 1'b0, 1'b0);
    #7;
    check(drop_count_o == 8'd0, "R1 drop cleared", int'(drop_count_o), 0);
    @(negedge clk); rst = 1'b0;
    base = wr_total;
    step(24'h0ABCDE, 1'b0, 1'b0);
    step(24'h0FEDCB, 1'b1, 1'b0);
    drain(10);
    check(wr_total - base == NW, "R5 frame after reset", wr_total - base, NW);
    check(head == tail, "R6 all words matched", tail - head, 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule